// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Control Aliases

A memory-mapped bank of general-purpose I/O control for 135 pins. For every pin it holds a direction bit, an output value, a pull enable and a pull polarity, each kept sixteen pins to a 16-bit word. Software never reads a control word back to modify it. Instead, each control register has two write aliases. One turns on the bits written as one. The other turns them off. Bits written as zero are left alone in both cases.

Each pin also has a 3-bit function code. The codes are packed five to a 16-bit word. The bank exposes the codes to the surrounding pin mux and does not interpret them, except that code 0 means plain GPIO. Pad levels pass through a two-stage synchronizer and can then be read as a read-only word.

Read data is combinational from the address. Writes take effect at the clock edge on which `req_i` and `we_i` are both high.

Top module: `gpio_bank`

## Requirements
- R1: After reset all pins are inputs (`oe_o` zero), `dout_o`, `pull_up_o`, `pull_dn_o` and `mode_o` are zero, and every register reads 0.
- R2: `addr_i[7:4]` selects the group and `addr_i[3:0]` the word: 0/1 direction set/clear, 2/3 output set/clear, 4/5 pull-enable set/clear, 6/7 pull-select set/clear, 8 pad input. A write to a set alias sets every bit written as one and keeps the bits written as zero.
- R3: A write to a clear alias clears every bit written as one and keeps the bits written as zero.
- R4: Pin N sits at word N/16, bit N%16. Reads of either the set alias or the clear alias return the current register word. Bits for pins above 134 read 0.
- R5: `oe_o[N]` is the direction bit of pin N (1 = output) and `dout_o[N]` is its output data bit.
- R6: `pull_up_o[N]` is high when pin N has both pull enable and pull select set. `pull_dn_o[N]` is high when pull enable is set and pull select is clear. With pull enable clear, both are low.
- R7: Mode words sit at `addr_i[7:5]` = 3'b101, word index `addr_i[4:0]` (0..26). Pin N uses word N/5, bits (N%5)*3 +: 3, and `mode_o[N*3 +: 3]` carries the code. A write replaces the whole word. Bit 15 reads 0.
- R8: A pad word (group 8) returns the pad levels after two clock edges of synchronization: one edge after a pad change the old level is still read, and after the second edge the new level is read. Writes to the pad group have no effect.
- R9: Addresses outside the map (control or pad word index 9..15, mode word index 27..31, groups 9 and 12..15) read 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| pad_i | input | 135 | Pad input levels |
| oe_o | output | 135 | Output enable per pin |
| dout_o | output | 135 | Output data per pin |
| pull_up_o | output | 135 | Pull-up active per pin |
| pull_dn_o | output | 135 | Pull-down active per pin |
| mode_o | output | 405 | Packed 3-bit function code per pin |

## Verification
The assertions check on every cycle that a set or clear write drives pin 0's enable one cycle later, and that the enable vector holds steady when no direction write occurs. They also check that pull-up and pull-down are never active together, that a write to mode word 0 appears on the first five codes, and that the codes hold steady when no mode write occurs. Only the bench scenarios can show the following: the word and bit placement at both ends of the pin range, that zero-written bits are kept, that unused bits are masked, the two-edge latency of the pad path, and that unmapped or read-only addresses are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W        = 16;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned MODE_W       = 3;
  localparam int unsigned MODE_PER_REG = 5;
  localparam int unsigned WIDX_W       = 4;
  localparam int unsigned MIDX_W       = 5;

  typedef enum logic [3:0] {
    GRP_DIR_SET  = 4'h0,
    GRP_DIR_CLR  = 4'h1,
    GRP_OUT_SET  = 4'h2,
    GRP_OUT_CLR  = 4'h3,
    GRP_PEN_SET  = 4'h4,
    GRP_PEN_CLR  = 4'h5,
    GRP_PSEL_SET = 4'h6,
    GRP_PSEL_CLR = 4'h7,
    GRP_PAD      = 4'h8
  } grp_e;

  localparam logic [2:0] MODE_SEG = 3'b101;
endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int unsigned NUM_PINS = 135,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (idx_i == IDX_W'(p / REG_W) && wdata_i[p % REG_W]) begin
          if (set_i)      q_q[p] <= 1'b1;
          else if (clr_i) q_q[p] <= 1'b0;
        end
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank #(
  parameter int unsigned NUM_PINS = 135,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned PER_REG  = 5,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [NUM_PINS*MODE_W-1:0] mode_o
);
  logic [NUM_PINS*MODE_W-1:0] mode_q;

  // whole-word replace: every field of the addressed word is loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (we_i) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (idx_i == IDX_W'(p / PER_REG))
          mode_q[p*MODE_W +: MODE_W] <= wdata_i[(p % PER_REG)*MODE_W +: MODE_W];
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 135
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 135
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  input  logic [NUM_PINS-1:0]        pad_i,
  output logic [NUM_PINS-1:0]        oe_o,
  output logic [NUM_PINS-1:0]        dout_o,
  output logic [NUM_PINS-1:0]        pull_up_o,
  output logic [NUM_PINS-1:0]        pull_dn_o,
  output logic [NUM_PINS*MODE_W-1:0] mode_o
);
  localparam int unsigned NUM_WORDS  = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int unsigned NUM_MREGS  = (NUM_PINS + MODE_PER_REG - 1) / MODE_PER_REG;
  localparam int unsigned FIELD_BITS = MODE_PER_REG * MODE_W;
  localparam int unsigned NUM_CTRL   = 4;   // dir, out, pull enable, pull select
  localparam int unsigned WPAD_W     = NUM_WORDS * REG_W;
  localparam int unsigned MPAD_W     = NUM_MREGS * FIELD_BITS;

  logic [3:0]        grp;
  logic [WIDX_W-1:0] widx;
  logic [MIDX_W-1:0] midx;
  logic              wr, mode_sel;

  assign grp      = addr_i[7:4];
  assign widx     = addr_i[WIDX_W-1:0];
  assign midx     = addr_i[MIDX_W-1:0];
  assign wr       = req_i & we_i;
  assign mode_sel = (addr_i[7:5] == MODE_SEG);

  logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];
  logic [WPAD_W-1:0]   rd_word [NUM_CTRL+1];
  logic [NUM_PINS-1:0] din_q;
  logic [NUM_PINS*MODE_W-1:0] mode_q;
  logic [MPAD_W-1:0]   mode_pad;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    gpio_setclr_bank #(
      .NUM_PINS(NUM_PINS), .REG_W(REG_W), .IDX_W(WIDX_W)
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr && grp == 4'(2*g)),
      .clr_i  (wr && grp == 4'(2*g+1)),
      .idx_i  (widx),
      .wdata_i(wdata_i),
      .q_o    (ctrl_q[g])
    );
    assign rd_word[g] = WPAD_W'(ctrl_q[g]);
  end

  gpio_mode_bank #(
    .NUM_PINS(NUM_PINS), .REG_W(REG_W), .MODE_W(MODE_W),
    .PER_REG(MODE_PER_REG), .IDX_W(MIDX_W)
  ) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && mode_sel),
    .idx_i  (midx),
    .wdata_i(wdata_i),
    .mode_o (mode_q)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (din_q)
  );

  assign rd_word[NUM_CTRL] = WPAD_W'(din_q);
  assign mode_pad          = MPAD_W'(mode_q);

  always_comb begin
    rdata_o = '0;
    if (mode_sel) begin
      if (int'(midx) < NUM_MREGS)
        rdata_o = REG_W'(mode_pad[int'(midx)*FIELD_BITS +: FIELD_BITS]);
    end else if (grp <= GRP_PAD) begin
      if (int'(widx) < NUM_WORDS) begin
        if (grp == GRP_PAD)
          rdata_o = rd_word[NUM_CTRL][int'(widx)*REG_W +: REG_W];
        else
          rdata_o = rd_word[int'(grp[2:1])][int'(widx)*REG_W +: REG_W];
      end
    end
  end

  assign oe_o      = ctrl_q[0];
  assign dout_o    = ctrl_q[1];
  assign pull_up_o = ctrl_q[2] & ctrl_q[3];
  assign pull_dn_o = ctrl_q[2] & ~ctrl_q[3];
  assign mode_o    = mode_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 135
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [REG_W-1:0]           wdata_i,
  input logic [NUM_PINS-1:0]        oe_o,
  input logic [NUM_PINS-1:0]        pull_up_o,
  input logic [NUM_PINS-1:0]        pull_dn_o,
  input logic [NUM_PINS*MODE_W-1:0] mode_o
);
  logic wr;
  assign wr = req_i & we_i;

  AST_DIR_SET_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == 8'h00 && wdata_i[0] |=> oe_o[0]); // R2
  AST_DIR_CLR_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == 8'h10 && wdata_i[0] |=> !oe_o[0]); // R3
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (addr_i[7:4] == 4'h0 || addr_i[7:4] == 4'h1)) |=> $stable(oe_o)); // R9
  AST_DIR_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i[7:5] == 3'b000 && wdata_i == '0 |=> $stable(oe_o)); // R2
  AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_dn_o) == '0); // R6
  AST_MODE_WORD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == 8'hA0 |=> mode_o[14:0] == $past(wdata_i[14:0])); // R7
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i[7:5] == MODE_SEG) |=> $stable(mode_o)); // R7
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .oe_o     (oe_o),
  .pull_up_o(pull_up_o),
  .pull_dn_o(pull_dn_o),
  .mode_o   (mode_o)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int NP = 135;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NP-1:0] pad = '0;
  logic [NP-1:0] oe, dout, pu, pd;
  logic [NP*3-1:0] mode;

  int total = 0, bad = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .oe_o(oe), .dout_o(dout),
    .pull_up_o(pu), .pull_dn_o(pd), .mode_o(mode)
  );

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic chk(input string t, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #2;
      if (req && !we && exp_q.size() > 0) begin
        logic [15:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s addr=%0h actual=%0h expected=%0h", t, addr, rdata, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] pat;
    logic [143:0]  ppad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", 512'(oe), '0);
    chk("R1 dout", 512'(dout), '0);
    chk("R1 pulls", 512'({pu, pd}), '0);
    chk("R1 mode", 512'(mode), '0);
    rd(8'h00, 16'h0000, "R1 dir word0");
    rd(8'hA0, 16'h0000, "R1 mode word0");

    // R2/R3/R4/R5 direction set/clear
    wr(8'h00, 16'h00A5);
    rd(8'h00, 16'h00A5, "R2 dir set");
    chk("R5 oe low byte", 512'(oe[7:0]), 512'(8'hA5));
    wr(8'h00, 16'h0100);
    rd(8'h00, 16'h01A5, "R2 zero bits kept");
    wr(8'h10, 16'h0005);
    rd(8'h00, 16'h01A0, "R3 dir clear");
    rd(8'h10, 16'h01A0, "R4 clear alias read");
    chk("R5 oe after clear", 512'(oe[15:0]), 512'(16'h01A0));

    // R4 top word, unused bits; R5 output data
    wr(8'h28, 16'hFFFF);
    rd(8'h28, 16'h007F, "R4 top word mask");
    chk("R5 dout top", 512'(dout[134:128]), 512'(7'h7F));
    wr(8'h38, 16'h0040);
    rd(8'h38, 16'h003F, "R3 clear pin 134");
    chk("R5 dout pin134", 512'(dout[134]), '0);

    // R6 pulls
    wr(8'h41, 16'h000F);
    wr(8'h61, 16'h0003);
    chk("R6 pull up", 512'(pu[19:16]), 512'(4'b0011));
    chk("R6 pull down", 512'(pd[19:16]), 512'(4'b1100));
    wr(8'h62, 16'h0001);
    chk("R6 select without enable", 512'({pu[32], pd[32]}), '0);
    wr(8'h51, 16'h0001);
    chk("R6 enable cleared", 512'({pu[16], pd[16]}), '0);

    // R7 mode packing
    wr(8'hA0, 16'h1234);
    rd(8'hA0, 16'h1234, "R7 mode word0");
    chk("R7 pin1 code", 512'(mode[5:3]), 512'(3'd6));
    chk("R7 pin4 code", 512'(mode[14:12]), 512'(3'd1));
    wr(8'hBA, 16'hFFFF);
    rd(8'hBA, 16'h7FFF, "R7 bit15 reads 0");
    wr(8'hBA, 16'h0001);
    chk("R7 whole write", 512'(mode[404:390]), 512'(15'h0001));

    // R8 pad sync
    for (int i = 0; i < NP; i++) pat[i] = ((i * 7 + 3) % 5) < 2;
    @(negedge clk); pad = pat;
    ppad = 144'(pat);
    rd(8'h80, 16'h0000, "R8 one edge still old");
    rd(8'h80, ppad[15:0], "R8 word0 after sync");
    rd(8'h88, ppad[143:128], "R8 top word");
    rd(8'h84, ppad[79:64], "R8 word4");
    wr(8'h80, 16'hFFFF);
    rd(8'h80, ppad[15:0], "R8 pad write ignored");

    // R9 unmapped
    wr(8'h0F, 16'hFFFF);
    rd(8'h00, 16'h01A0, "R9 dir word15 write ignored");
    chk("R9 oe unchanged", 512'(oe), 512'(135'h01A0));
    rd(8'h09, 16'h0000, "R9 word9 reads 0");
    wr(8'hBB, 16'h7FFF);
    rd(8'hBB, 16'h0000, "R9 mode word27");
    chk("R9 mode unchanged", 512'(mode[404:0]), 512'({15'h0001, 375'h0, 15'h1234}));
    wr(8'hF0, 16'hFFFF);
    rd(8'hF0, 16'h0000, "R9 group15 reads 0");
    rd(8'h90, 16'h0000, "R9 group9 reads 0");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard all-R actual=%0d expected=0 pending", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule